// File: doc/BRIEF.md
# LED Printhead Line Loader

This block moves one print line of dot data from a line buffer into an LED printhead and then lights it. The head is fed over four parallel serial data lanes that share one head clock, so every head clock carries four neighbouring dots. With the default size of 4992 dots, a line takes 1248 head clocks. Once the last dots have been shifted, a load pulse copies the head's shift registers into its driver latches. Four active-low strobes then light the four driver groups one after another, each for a programmable number of cycles. The dot groups are 1–1248, 1249–2496, 2497–3744 and 3745–4992.

Software or a line sequencer starts a line with a request/acknowledge handshake. The on-time and the minimum load-to-load spacing are presented with the request and captured when it is accepted. The next line can be accepted and shifted while the previous line's strobes are still running. Its load pulse is held back until those strobes have ended and the spacing has elapsed.

The shift controller has six states. SH_IDLE waits for a request and acknowledges it. SH_PREF waits for the first buffer word. SH_LO is the head clock low phase with new data. SH_HI is the head clock high phase. SH_HOLD waits for permission to load. SH_LOAD drives the load pulse. Its transitions are:
- SH_IDLE→SH_PREF on a request.
- SH_PREF→SH_LO always.
- SH_LO→SH_HI always.
- SH_HI→SH_LO while words remain.
- SH_HI→SH_HOLD after the last word.
- SH_HOLD→SH_LOAD when the strobes are idle and the spacing timer is zero.
- SH_LOAD→SH_IDLE after the load width.

The strobe sequencer has two states. ST_IDLE→ST_ON happens on a fire request from the end of SH_LOAD. ST_ON steps through groups 0 to 3. ST_ON→ST_IDLE happens when group 3's on-time ends.

Top module: `lh_line_loader`

## Requirements
- R1: After reset, head_clk, head_dat, head_load, line_ack and line_busy are 0, and all bits of head_stb_n are 1.
- R2: line_ack is a single-cycle pulse, given combinationally in the cycle where line_req is high and the loader is idle. line_busy is high from the cycle after acceptance until the load pulse ends.
- R3: Buffer word k holds dots 4k+1..4k+4, with bit i holding dot 4k+i+1. Read data arrives one cycle after rd_en. The loader reads addresses 0, 1, …, 1247, each once, in that order.
- R4: On the k-th rising edge of head_clk in a line (k counted from 0), head_dat[i] carries dot 4k+i+1. The left edge is sent first, and a line has exactly 1248 rising edges before its load pulse.
- R5: head_dat never changes in a cycle in which head_clk rises.
- R6: After the last head clock, head_load is high for exactly LOAD_CYC (default 2) consecutive cycles, and head_clk is low throughout.
- R7: Strobes go low in the order 0, 1, 2, 3. They run back to back and never overlap. Strobe 0 goes low in the first cycle in which head_load is low again.
- R8: Each strobe stays low for the on-time captured at acceptance, in cycles. An on-time of 0 is treated as 1.
- R9: No strobe is low while head_load is high.
- R10: A new line is accepted and shifted while the previous line's strobes are still active.
- R11: A line's load pulse does not start until every strobe of the previous line has ended.
- R12: The spacing between the rising edges of two consecutive load pulses is at least the line period captured for the earlier line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_req | input | 1 | Request to start a line |
| cfg_on_time | input | 16 | Strobe on-time in cycles, captured on acceptance |
| cfg_period | input | 20 | Minimum load-to-load spacing in cycles, captured on acceptance |
| line_ack | output | 1 | Acceptance pulse |
| line_busy | output | 1 | Line is being shifted or loaded |
| rd_en | output | 1 | Buffer read enable |
| rd_addr | output | 11 | Buffer word address (dot group) |
| rd_data | input | 4 | Buffer word, valid one cycle after rd_en |
| head_clk | output | 1 | Head shift clock |
| head_dat | output | 4 | Head serial data lanes |
| head_load | output | 1 | Head latch pulse |
| head_stb_n | output | 4 | Active-low strobes, one per driver group |

## Verification
A wrong shift counter or address shows up at the ports within a single line. The bench sees either a head clock count other than 1248 or misplaced dots when it rebuilds the 4992-dot line at the load pulse. A wrong strobe state appears within one strobe window, as a wrong order, an overlap or a wrong width. The overlap cases are driven deliberately: a long on-time followed at once by the next request, then a large line period. A gating error therefore surfaces at the very next load pulse, as a load during strobes or a load that comes too early.

// File: rtl/lh_pkg.sv
package lh_pkg;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_PREF,
        SH_LO,
        SH_HI,
        SH_HOLD,
        SH_LOAD
    } sh_state_t;

    typedef enum logic {
        ST_IDLE,
        ST_ON
    } st_state_t;

endpackage

// File: rtl/lh_shift_fsm.sv
module lh_shift_fsm
    import lh_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int CLKS     = 1248,
    parameter int AW       = 11,
    parameter int ONT_W    = 16,
    parameter int PER_W    = 20,
    parameter int LOAD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_req,
    input  logic [ONT_W-1:0] cfg_on_time,
    input  logic [PER_W-1:0] cfg_period,
    output logic             line_ack,
    output logic             line_busy,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic [LANES-1:0] rd_data,
    output logic             hclk,
    output logic [LANES-1:0] hdat,
    output logic             hload,
    input  logic             strobe_busy,
    output logic             fire,
    output logic [ONT_W-1:0] fire_on_time
);

    localparam logic [AW-1:0] LAST    = AW'(CLKS - 1);
    localparam int            LCW     = (LOAD_CYC > 1) ? $clog2(LOAD_CYC) : 1;
    localparam logic [LCW-1:0] LD_LAST = LCW'(LOAD_CYC - 1);

    sh_state_t        state, nstate;
    logic [AW-1:0]    cnt;
    logic [LCW-1:0]   ld_cnt;
    logic [PER_W-1:0] per_left;
    logic [PER_W-1:0] per_sh;
    logic [ONT_W-1:0] ont_sh;
    logic             hclk_q;
    logic             hload_q;
    logic [LANES-1:0] hdat_q;

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            SH_IDLE: if (line_req) nstate = SH_PREF;
            SH_PREF: nstate = SH_LO;
            SH_LO:   nstate = SH_HI;
            SH_HI:   nstate = (cnt == LAST) ? SH_HOLD : SH_LO;
            SH_HOLD: if (!strobe_busy && per_left == '0) nstate = SH_LOAD;
            SH_LOAD: if (ld_cnt == LD_LAST) nstate = SH_IDLE;
            default: nstate = SH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= nstate;
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            ld_cnt   <= '0;
            per_left <= '0;
            per_sh   <= '0;
            ont_sh   <= '0;
            hclk_q   <= 1'b0;
            hload_q  <= 1'b0;
            hdat_q   <= '0;
        end else begin
            if (state == SH_HOLD && nstate == SH_LOAD)
                per_left <= per_sh;
            else if (per_left != '0)
                per_left <= per_left - 1'b1;

            unique case (state)
                SH_IDLE: begin
                    if (line_req) begin
                        ont_sh <= cfg_on_time;
                        per_sh <= cfg_period;
                        cnt    <= '0;
                    end
                end
                SH_PREF: hdat_q <= rd_data;
                SH_LO:   hclk_q <= 1'b1;
                SH_HI: begin
                    hclk_q <= 1'b0;
                    if (cnt != LAST) begin
                        hdat_q <= rd_data;
                        cnt    <= cnt + 1'b1;
                    end
                end
                SH_HOLD: begin
                    if (nstate == SH_LOAD) begin
                        hload_q <= 1'b1;
                        ld_cnt  <= '0;
                    end
                end
                SH_LOAD: begin
                    ld_cnt <= ld_cnt + 1'b1;
                    if (nstate == SH_IDLE) hload_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign line_ack     = (state == SH_IDLE) && line_req;
    assign line_busy    = (state != SH_IDLE);
    assign rd_en        = line_ack || (state == SH_LO && cnt != LAST);
    assign rd_addr      = (state == SH_IDLE) ? '0 : cnt + 1'b1;
    assign fire         = (state == SH_LOAD) && (ld_cnt == LD_LAST);
    assign fire_on_time = ont_sh;
    assign hclk         = hclk_q;
    assign hload        = hload_q;
    assign hdat         = hdat_q;

endmodule

// File: rtl/lh_strobe_fsm.sv
module lh_strobe_fsm
    import lh_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int ONT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ONT_W-1:0]  on_time,
    output logic [GROUPS-1:0] stb_n,
    output logic              busy
);

    localparam int            GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam logic [GW-1:0] GLAST = GW'(GROUPS - 1);

    st_state_t         state, nstate;
    logic [GW-1:0]     grp;
    logic [ONT_W-1:0]  left;
    logic [ONT_W-1:0]  ont_q;
    logic [ONT_W-1:0]  ont_eff;
    logic [GROUPS-1:0] stb_q;

    assign ont_eff = (on_time == '0) ? ONT_W'(1) : on_time;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (fire) nstate = ST_ON;
            ST_ON:   if (left == ONT_W'(1) && grp == GLAST) nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp   <= '0;
            left  <= '0;
            ont_q <= '0;
            stb_q <= '1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (fire) begin
                        grp   <= '0;
                        ont_q <= ont_eff;
                        left  <= ont_eff;
                        stb_q <= ~GROUPS'(1);
                    end
                end
                ST_ON: begin
                    if (left == ONT_W'(1)) begin
                        if (grp == GLAST) begin
                            stb_q <= '1;
                        end else begin
                            grp   <= grp + 1'b1;
                            left  <= ont_q;
                            stb_q <= ~(GROUPS'(1) << (grp + 1'b1));
                        end
                    end else begin
                        left <= left - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign stb_n = stb_q;
    assign busy  = (state == ST_ON);

endmodule

// File: rtl/lh_line_loader.sv
module lh_line_loader #(
    parameter int DOTS     = 4992,
    parameter int LANES    = 4,
    parameter int GROUPS   = 4,
    parameter int ONT_W    = 16,
    parameter int PER_W    = 20,
    parameter int LOAD_CYC = 2,
    localparam int CLKS    = DOTS / LANES,
    localparam int AW      = $clog2(CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_req,
    input  logic [ONT_W-1:0]  cfg_on_time,
    input  logic [PER_W-1:0]  cfg_period,
    output logic              line_ack,
    output logic              line_busy,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [LANES-1:0]  rd_data,
    output logic              head_clk,
    output logic [LANES-1:0]  head_dat,
    output logic              head_load,
    output logic [GROUPS-1:0] head_stb_n
);

    logic             fire;
    logic [ONT_W-1:0] fire_on_time;
    logic             strobe_busy;

    lh_shift_fsm #(
        .LANES(LANES), .CLKS(CLKS), .AW(AW), .ONT_W(ONT_W),
        .PER_W(PER_W), .LOAD_CYC(LOAD_CYC)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .line_req(line_req),
        .cfg_on_time(cfg_on_time), .cfg_period(cfg_period),
        .line_ack(line_ack), .line_busy(line_busy),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .hclk(head_clk), .hdat(head_dat), .hload(head_load),
        .strobe_busy(strobe_busy), .fire(fire), .fire_on_time(fire_on_time)
    );

    lh_strobe_fsm #(
        .GROUPS(GROUPS), .ONT_W(ONT_W)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .fire(fire), .on_time(fire_on_time),
        .stb_n(head_stb_n), .busy(strobe_busy)
    );

endmodule

// File: rtl/lh_line_loader_chk.sv
module lh_line_loader_chk #(
    parameter int LANES  = 4,
    parameter int GROUPS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_ack,
    input logic              head_clk,
    input logic [LANES-1:0]  head_dat,
    input logic              head_load,
    input logic [GROUPS-1:0] head_stb_n
);

    assert_single_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_ack |=> !line_ack);

    assert_dat_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(head_clk) |-> $stable(head_dat));

    assert_load_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        head_load |-> !head_clk);

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~head_stb_n) <= 1);

    assert_no_stb_in_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        head_load |-> (&head_stb_n));

endmodule

bind lh_line_loader lh_line_loader_chk #(.LANES(LANES), .GROUPS(GROUPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_ack(line_ack), .head_clk(head_clk),
    .head_dat(head_dat), .head_load(head_load), .head_stb_n(head_stb_n)
);

// File: tb/tb_lh_line_loader.sv
`timescale 1ns/1ps
module tb_lh_line_loader;

    localparam int DOTS = 4992, LANES = 4, GROUPS = 4, LOAD_CYC = 2;
    localparam int CLKS = DOTS / LANES;
    localparam int AW = $clog2(CLKS);

    logic clk = 1'b0, rst_n = 1'b0, line_req = 1'b0;
    logic [15:0] cfg_on_time = '0;
    logic [19:0] cfg_period = '0;
    logic line_ack, line_busy, rd_en, head_clk, head_load;
    logic [AW-1:0] rd_addr;
    logic [LANES-1:0] rd_data = '0, head_dat;
    logic [GROUPS-1:0] head_stb_n;

    always #2.5 clk = ~clk;

    lh_line_loader dut (
        .clk(clk), .rst_n(rst_n), .line_req(line_req), .cfg_on_time(cfg_on_time),
        .cfg_period(cfg_period), .line_ack(line_ack), .line_busy(line_busy),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .head_clk(head_clk),
        .head_dat(head_dat), .head_load(head_load), .head_stb_n(head_stb_n)
    );

    logic [LANES-1:0] mem [0:CLKS-1];
    bit dots [1:DOTS];
    bit cap  [1:DOTS];

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    int nchk = 0, nfail = 0;
    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // monitor state
    int cyc = 0, edge_k = 0, addr_exp = 0, addr_err = 0, ld_len = 0, ld_fall = 0;
    int n_loads = 0, last_ld = 0, prev_per = 0, stb_exp = 0, cur_g = -1;
    int widths [GROUPS];
    int sh_ont = 0, sh_per = 0;
    bit has_prev = 0, stb_pend = 0, ack_in_stb = 0, prev_clk = 0, prev_ld = 0;
    logic [GROUPS-1:0] prev_act = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            logic [GROUPS-1:0] act;
            act = ~head_stb_n;
            if (line_ack) begin
                sh_ont = int'(cfg_on_time); sh_per = int'(cfg_period);
                edge_k = 0; addr_exp = 0; addr_err = 0;
                ack_in_stb = (act != '0);
            end
            if (rd_en) begin
                if (int'(rd_addr) != addr_exp) addr_err++;
                addr_exp++;
            end
            if (head_clk && !prev_clk) begin
                if (edge_k < CLKS)
                    for (int i = 0; i < LANES; i++) cap[4*edge_k+i+1] = head_dat[i];
                edge_k++;
            end
            if (head_load && !prev_ld) begin
                int mism;
                mism = 0;
                for (int d = 1; d <= DOTS; d++) if (cap[d] != dots[d]) mism++;
                chk(edge_k == CLKS, "R4 clock count", edge_k, CLKS);
                chk(mism == 0, "R4 dot placement", mism, 0);
                chk(addr_err == 0 && addr_exp == CLKS, "R3 read sequence", addr_exp, CLKS);
                chk(&head_stb_n, "R9 strobe idle at load", int'(head_stb_n), 15);
                chk(!stb_pend, "R11 previous strobes finished", int'(stb_pend), 0);
                if (has_prev) chk(cyc - last_ld >= prev_per, "R12 load spacing", cyc - last_ld, prev_per);
                has_prev = 1; last_ld = cyc; prev_per = sh_per;
                stb_exp = (sh_ont == 0) ? 1 : sh_ont;
                stb_pend = 1; cur_g = -1;
                for (int g = 0; g < GROUPS; g++) widths[g] = 0;
                ld_len = 0; n_loads++;
            end
            if (head_load) begin
                ld_len++;
                if (head_clk) chk(0, "R6 head clock during load", 1, 0);
            end
            if (!head_load && prev_ld) begin
                chk(ld_len == LOAD_CYC, "R6 load width", ld_len, LOAD_CYC);
                chk(!line_busy, "R2 busy drops after load", int'(line_busy), 0);
                ld_fall = cyc;
            end
            if (act != '0) begin
                int g;
                g = 0;
                for (int j = GROUPS - 1; j >= 0; j--) if (act[j]) g = j;
                if (g != cur_g) begin
                    if (cur_g < 0) chk(cyc == ld_fall, "R7 first strobe timing", cyc - ld_fall, 0);
                    chk(g == cur_g + 1, "R7 strobe order", g, cur_g + 1);
                    cur_g = g;
                end
                widths[g]++;
            end else if (prev_act[GROUPS-1]) begin
                for (int g = 0; g < GROUPS; g++) chk(widths[g] == stb_exp, "R8 strobe width", widths[g], stb_exp);
                stb_pend = 0;
            end
            prev_act = act; prev_clk = head_clk; prev_ld = head_load;
        end
    end

    function automatic bit pat_bit(input int pat, input int d);
        case (pat)
            1: return 1'b1;
            2: return bit'(d % 2);
            3: return bit'((d % 97) == 0);
            default: return bit'($urandom % 2);
        endcase
    endfunction

    task automatic run_line(input int ont, input int per, input int pat);
        @(negedge clk);
        while (line_busy) @(negedge clk);
        for (int d = 1; d <= DOTS; d++) dots[d] = pat_bit(pat, d);
        for (int k = 0; k < CLKS; k++)
            for (int i = 0; i < LANES; i++) mem[k][i] = dots[4*k+i+1];
        @(posedge clk); #1;
        cfg_on_time = 16'(ont); cfg_period = 20'(per); line_req = 1'b1;
        @(negedge clk);
        while (!line_ack) @(negedge clk);
        @(posedge clk); #1 line_req = 1'b0;
        @(negedge clk);
        chk(line_busy && !line_ack, "R2 busy after accept", int'(line_busy), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R2 actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed_1ce5);
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!head_clk && head_dat == '0 && !head_load && &head_stb_n && !line_ack && !line_busy,
            "R1 reset state", int'(head_stb_n), 15);

        run_line(1, 0, 1);
        run_line(0, 0, 2);
        run_line(1000, 0, 0);
        run_line(5, 6000, 0);
        chk(ack_in_stb, "R10 accept during strobes", int'(ack_in_stb), 1);
        run_line(3, 0, 3);
        for (int n = 0; n < 8; n++)
            run_line(int'($urandom % 300), int'($urandom % 5000), 0);

        @(negedge clk);
        while (n_loads < 13 || stb_pend || line_busy) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(n_loads == 13, "R4 lines loaded", n_loads, 13);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule